// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-port synchronous static RAM with a late-write protocol. On each rising clock edge it captures an address, an active-low chip select, an active-low write strobe and one active-low enable per 9-bit lane. A write supplies its data one rising edge after its address. That data lands in a single-entry write buffer and moves into the storage array at the following edge. Reads can therefore follow writes with no idle cycle between them.

A read returns its word in the cycle in which it is issued. The data drivers turn on at the falling edge of that cycle. If a read targets the word that is still waiting in the write buffer, the buffered lanes are merged over the array word, so the read always sees the latest value. The drivers turn off in the same cycle for a write or a deselect. An asynchronous active-low output enable can also turn them off at any time. While the drivers are off, the data output is forced to zero, and that state stands for high impedance.

Top module: `lw_sram`

## Requirements
- R1: Address, select, write strobe and lane enables take effect only as sampled at a rising edge. A cycle with `sel_n` high changes no stored word, whatever the other inputs are.
- R2: The data for a write is the value on `din` at the rising edge after the edge that captured the write. The value on `din` at the write's own edge is not stored.
- R3: For a read captured at a rising edge, `dq_drive` goes high at the following falling edge, and `dout` shows the word until the next rising edge. When the previous cycle was also a read, `dq_drive` stays high across the rising edge.
- R4: The word is made of 9-bit lanes. Lane i covers bits [9i+8:9i] and is written when `lane_n[i]` is 0. With all lane enables at 0 the whole word is written.
- R5: Lane enables have no effect on a read. The whole word is returned for any `lane_n` value.
- R6: A selected write with all lane enables at 1 changes no stored word. The drivers are still off in that cycle.
- R7: A read of the address whose write data was taken at the same edge returns the newly written lanes, merged over the stored word.
- R8: In a cycle captured as a write or a deselect, `dq_drive` is 0 for the whole cycle. Whenever `dq_drive` is 0, `dout` is 0.
- R9: `oe_n` high forces `dq_drive` low at once. Bringing `oe_n` low during a read cycle, after the falling edge, restores the drivers and the data with no clock edge.
- R10: After reset `dq_drive` is 0, `dout` is 0 and the write buffer holds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; capture on rising edge, drive enable on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| lane_n | input | DATA_W/9 | Per-lane write enables, active low |
| din | input | DATA_W | Write data, taken one edge after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | DATA_W | Read data; zero while not driving |
| dq_drive | output | 1 | High when the data drivers are on |

## Verification
The main collision is a buffer retire and a read hit in the same cycle. At one rising edge, the previous write's data enters the buffer, the older buffered word is committed to the array, and a read of the just-written address is captured. The bench provokes this by issuing every lane pattern as a write at every address, each followed at once by a read of that address. Each result is compared with a bench model that applies the late-arriving data before resolving the read. A second collision is a clocked drive turn-on meeting the asynchronous enable. This is checked by toggling `oe_n` inside a read cycle after its falling edge.

// File: rtl/lw_pkg.sv
package lw_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_VOID  = 2'd3
  } op_e;

  function automatic op_e op_decode(input logic sel_n, input logic wr_n,
                                    input logic any_lane);
    if (sel_n)         return OP_IDLE;
    else if (wr_n)     return OP_READ;
    else if (any_lane) return OP_WRITE;
    else               return OP_VOID;
  endfunction
endpackage

// File: rtl/lw_ctrl.sv
module lw_ctrl #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic              oe_n,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wp_vld,
  output logic [ADDR_W-1:0] wp_addr,
  output logic [LANES-1:0]  wp_mask,
  output logic              drive
);
  import lw_pkg::*;

  op_e  op_now;
  logic rd_q;
  logic half_q;

  assign op_now = op_decode(sel_n, wr_n, ~&lane_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      rd_addr <= '0;
      wp_vld  <= 1'b0;
      wp_addr <= '0;
      wp_mask <= '0;
    end else begin
      rd_q   <= (op_now == OP_READ);
      wp_vld <= (op_now == OP_WRITE);
      if (op_now == OP_READ) rd_addr <= addr;
      if (op_now == OP_WRITE) begin
        wp_addr <= addr;
        wp_mask <= ~lane_n;
      end
    end
  end

  // falling-edge stage: drivers come on half a cycle after a read is captured
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= rd_q;
  end

  assign drive = rd_q & half_q & ~oe_n;
endmodule

// File: rtl/lw_wbuf.sv
module lw_wbuf #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_vld,
  input  logic [ADDR_W-1:0] wp_addr,
  input  logic [LANES-1:0]  wp_mask,
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              buf_vld,
  output logic              cm_en,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [LANES-1:0]  cm_mask,
  output logic [DATA_W-1:0] cm_data,
  output logic              fwd_hit,
  output logic [DATA_W-1:0] rdata
);
  import lw_pkg::*;

  logic [ADDR_W-1:0] b_addr;
  logic [LANES-1:0]  b_mask;
  logic [DATA_W-1:0] b_data;

  function automatic logic [DATA_W-1:0] lane_merge(
      input logic [DATA_W-1:0] base, input logic [DATA_W-1:0] over,
      input logic [LANES-1:0] mask);
    logic [DATA_W-1:0] r;
    r = base;
    for (int i = 0; i < LANES; i++)
      if (mask[i]) r[i*LANE_W +: LANE_W] = over[i*LANE_W +: LANE_W];
    return r;
  endfunction

  // buffer fills on the edge after the write capture; it retires one edge later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_vld <= 1'b0;
      b_addr  <= '0;
      b_mask  <= '0;
      b_data  <= '0;
    end else begin
      buf_vld <= wp_vld;
      if (wp_vld) begin
        b_addr <= wp_addr;
        b_mask <= wp_mask;
        b_data <= din;
      end
    end
  end

  assign cm_en   = buf_vld;
  assign cm_addr = b_addr;
  assign cm_mask = b_mask;
  assign cm_data = b_data;
  assign fwd_hit = buf_vld && (b_addr == rd_addr);
  assign rdata   = fwd_hit ? lane_merge(arr_rdata, b_data, b_mask) : arr_rdata;
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wmask,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  import lw_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && wmask[g])
        mem[waddr][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 18
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr,
  input  logic                           sel_n,
  input  logic                           wr_n,
  input  logic [DATA_W/lw_pkg::LANE_W-1:0] lane_n,
  input  logic [DATA_W-1:0]              din,
  input  logic                           oe_n,
  output logic [DATA_W-1:0]              dout,
  output logic                           dq_drive
);
  localparam int LANES = DATA_W / lw_pkg::LANE_W;

  logic [ADDR_W-1:0] rd_addr;
  logic              wp_vld;
  logic [ADDR_W-1:0] wp_addr;
  logic [LANES-1:0]  wp_mask;
  logic              buf_vld;
  logic              cm_en;
  logic [ADDR_W-1:0] cm_addr;
  logic [LANES-1:0]  cm_mask;
  logic [DATA_W-1:0] cm_data;
  logic              fwd_hit;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] rdata;

  lw_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .wr_n(wr_n),
    .lane_n(lane_n), .oe_n(oe_n), .rd_addr(rd_addr), .wp_vld(wp_vld),
    .wp_addr(wp_addr), .wp_mask(wp_mask), .drive(dq_drive));

  lw_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .wp_vld(wp_vld), .wp_addr(wp_addr),
    .wp_mask(wp_mask), .din(din), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .buf_vld(buf_vld), .cm_en(cm_en), .cm_addr(cm_addr), .cm_mask(cm_mask),
    .cm_data(cm_data), .fwd_hit(fwd_hit), .rdata(rdata));

  lw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_array (
    .clk(clk), .we(cm_en), .waddr(cm_addr), .wmask(cm_mask),
    .wdata(cm_data), .raddr(rd_addr), .rdata(arr_rdata));

  assign dout = dq_drive ? rdata : '0;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_n,
  input logic             wr_n,
  input logic [LANES-1:0] lane_n,
  input logic             oe_n,
  input logic             dq_drive,
  input logic             wp_vld,
  input logic             buf_vld,
  input logic             fwd_hit
);
  assert_off_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !wr_n) |=> !dq_drive);

  assert_oe_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_drive);

  assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && wr_n) |=> (dq_drive || oe_n));

  assert_void_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wr_n && (&lane_n)) |=> !wp_vld);

  assert_buf_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_vld |-> $past(wp_vld));

  assert_hit_needs_buf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> buf_vld);
endmodule

bind lw_sram lw_sram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .lane_n(lane_n),
  .oe_n(oe_n), .dq_drive(dq_drive), .wp_vld(wp_vld), .buf_vld(buf_vld),
  .fwd_hit(fwd_hit));

// File: tb/sim_lw_sram.sv
`timescale 1ns/1ps
module sim_lw_sram;
  localparam int AW = 4;
  localparam int DW = 18;
  localparam int NL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic sel_n = 1'b1;
  logic wr_n = 1'b1;
  logic [NL-1:0] lane_n = '1;
  logic [DW-1:0] din = '0;
  logic oe_n = 1'b0;
  logic [DW-1:0] dout;
  logic dq_drive;

  int n_cmp = 0;
  int n_bad = 0;

  logic [DW-1:0] ref_mem [16];
  logic pv = 1'b0;
  logic [AW-1:0] pa = '0;
  logic [NL-1:0] pm = '0;
  logic [DW-1:0] nd = '0;
  logic prev_rd = 1'b0;

  always #10 clk = ~clk;

  lw_sram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n), .wr_n(wr_n),
    .lane_n(lane_n), .din(din), .oe_n(oe_n), .dout(dout), .dq_drive(dq_drive));

  task automatic chk(input string req, input logic [DW-1:0] got,
                     input logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %h expected %h", req, $time, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 18'h0b35 + k * 18'h1d07) ^ 18'h2a5a5);
  endfunction

  // one bus cycle: inputs set here are captured at the next rising edge
  task automatic step(input logic s_n, input logic w_n, input logic [NL-1:0] l_n,
                      input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input string req);
    logic rd;
    logic [DW-1:0] exp;
    sel_n = s_n; wr_n = w_n; lane_n = l_n; addr = a; din = nd;
    if (pv)
      for (int i = 0; i < NL; i++)
        if (pm[i]) ref_mem[pa][i*9 +: 9] = nd[i*9 +: 9];
    pv = !s_n && !w_n && (l_n != '1);
    pa = a; pm = ~l_n; nd = wd;
    rd = !s_n && w_n;
    exp = ref_mem[a];
    @(posedge clk); #5;
    if (rd) chk("R3 early drive", {17'd0, dq_drive}, {17'd0, prev_rd});
    else    chk("R8 early drive", {17'd0, dq_drive}, '0);
    #7;
    if (rd) begin
      chk("R3 drive", {17'd0, dq_drive}, 18'd1);
      chk(req, dout, exp);
    end else begin
      chk("R8 drive", {17'd0, dq_drive}, '0);
      chk("R8 dout", dout, '0);
    end
    prev_rd = rd;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #12;
    chk("R10 drive", {17'd0, dq_drive}, '0);
    chk("R10 dout", dout, '0);
    rst_n = 1'b1;
    @(posedge clk); #12;

    // full-word fill; each write's data rides on the next cycle's din
    for (int a = 0; a < 16; a++) step(1'b0, 1'b0, 2'b00, AW'(a), pat(a, 0), "R4");
    step(1'b1, 1'b1, 2'b11, '0, '0, "R8");
    // back-to-back reads, lane enables varied (ignored on reads)
    for (int a = 0; a < 16; a++) step(1'b0, 1'b1, NL'(a), AW'(a), '0, "R2");
    step(1'b1, 1'b1, 2'b11, '0, '0, "R8");

    // every lane pattern at every address, read back at once (forwarding)
    for (int a = 0; a < 16; a++)
      for (int m = 0; m < 4; m++) begin
        step(1'b0, 1'b0, NL'(m), AW'(a), pat(a, m + 1), "R8");
        step(1'b0, 1'b1, 2'b11, AW'(a), '0,
             (m == 3) ? "R6" : ((m == 0) ? "R4" : "R7"));
      end
    step(1'b1, 1'b1, 2'b11, '0, '0, "R8");
    for (int a = 0; a < 16; a++) step(1'b0, 1'b1, 2'b01, AW'(a), '0, "R5");

    // deselected cycles with write asserted must store nothing
    for (int a = 0; a < 16; a++) step(1'b1, 1'b0, 2'b00, AW'(a), pat(a, 9), "R8");
    for (int a = 0; a < 16; a++) step(1'b0, 1'b1, 2'b00, AW'(a), '0, "R1");

    // asynchronous output enable inside read cycles
    for (int a = 0; a < 4; a++) begin
      step(1'b0, 1'b1, 2'b00, AW'(a), '0, "R3");
      oe_n = 1'b1; #1;
      chk("R9 off", {17'd0, dq_drive}, '0);
      chk("R9 dout", dout, '0);
      oe_n = 1'b0; #1;
      chk("R9 on", {17'd0, dq_drive}, 18'd1);
      chk("R9 data", dout, ref_mem[a]);
    end
    step(1'b1, 1'b1, 2'b11, '0, '0, "R8");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule